// File: doc/BRIEF.md
# Floating-Point Load Address Generator

This block turns a decoded floating-point load into the values that the load/store pipe needs: the 64-bit effective address, the number of bytes to fetch, and whether the base register must be overwritten with that address. It covers four load kinds: single precision, double precision, signed word-as-integer and zero-extended word-as-integer. Each kind has an immediate-offset or register-offset addressing choice, and a choice to write the address back to the base register or not. Only ten of the sixteen combinations are legal. The six combinations that are not legal are reported through an error flag.

The issue stage presents the operation code, the base register number, the two register values and the 16-bit offset, together with a valid strobe. One cycle later the results appear on registered outputs. When no valid strobe arrives, the registered results keep their last values. The register file and the memory access itself are outside this block.

Top module: `fpl_agen`

## Requirements
- R1: The `op` input is laid out as bits [3:2] = kind (00 single, 01 double, 10 signed word, 11 zero-extended word), bit 1 = write-back form, and bit 0 = register-offset form. When bit 0 is 0, `ea` = base + sign-extended `disp`.
- R2: When `op` bit 0 is 1, `ea` = base + `rb_val`, taken modulo 2^64 with no carry out.
- R3: In a form without write-back (`op` bit 1 = 0), the base is the constant 0 when `ra_num` is 0, and `ra_val` otherwise.
- R4: In a write-back form (`op` bit 1 = 1), the base is always `ra_val`, even when `ra_num` is 0.
- R5: A legal write-back form raises `wb_en` and presents `wb_data` equal to `ea`. Forms without write-back keep `wb_en` at 0.
- R6: `nbytes` is 8 for the double kind and 4 for the single kind and both word kinds.
- R7: A word kind is legal only with register offset and no write-back (`op` bit 0 = 1, bit 1 = 0). Any other word combination raises `bad_form` and keeps `wb_en` at 0.
- R8: A write-back form with `ra_num` = 0 raises `bad_form` and keeps `wb_en` at 0.
- R9: Results appear one clock after a cycle with `valid_in` high, with `valid_out` high. After a cycle with `valid_in` low, `valid_out` is 0 and `ea`, `wb_en`, `wb_data`, `nbytes` and `bad_form` keep their values.
- R10: After synchronous reset, `valid_out`, `ea`, `wb_en`, `wb_data`, `nbytes` and `bad_form` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present this cycle |
| op | input | 4 | Kind, write-back and offset-form selection |
| ra_num | input | 5 | Base register number |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Offset register contents |
| disp | input | 16 | Signed immediate offset |
| valid_out | output | 1 | Results below are new this cycle |
| ea | output | 64 | Effective address |
| wb_en | output | 1 | Write `wb_data` back to the base register |
| wb_data | output | 64 | Value for base write-back |
| nbytes | output | 4 | Access size in bytes (4 or 8) |
| bad_form | output | 1 | Illegal operation combination |

## Verification
With the default output register, every result belongs to the clock edge that follows the cycle in which `valid_in` was high. The bench therefore drives inputs on a falling edge and compares all outputs on the next falling edge, after exactly one rising edge has stored them. Hold behaviour is checked by driving new random inputs with `valid_in` low, waiting one edge, and comparing the outputs against the previous expected values. Expected values come from a bench function that applies the requirements to the same inputs.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  localparam int OP_W    = 4;
  localparam int NBYTE_W = 4;

  typedef enum logic [1:0] {
    KIND_SGL = 2'b00,
    KIND_DBL = 2'b01,
    KIND_WSX = 2'b10,
    KIND_WZX = 2'b11
  } fpl_kind_e;

  typedef struct packed {
    logic               use_reg_ofs;
    logic               writes_base;
    logic [NBYTE_W-1:0] nbytes;
    logic               form_err;
  } fpl_ctl_t;

endpackage

// File: rtl/fpl_decode.sv
module fpl_decode
  import fpl_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output fpl_ctl_t        ctl
);

  fpl_kind_e kind;

  always_comb begin
    kind            = fpl_kind_e'(op[3:2]);
    ctl.use_reg_ofs = op[0];
    ctl.writes_base = op[1];
    unique case (kind)
      KIND_DBL: ctl.nbytes = NBYTE_W'(8);
      default:  ctl.nbytes = NBYTE_W'(4);
    endcase
    // word kinds only exist as register-offset, no write-back
    if (kind == KIND_WSX || kind == KIND_WZX)
      ctl.form_err = op[1] | ~op[0];
    else
      ctl.form_err = 1'b0;
  end

endmodule

// File: rtl/fpl_base_sel.sv
module fpl_base_sel #(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] ra_num,
  input  logic [XLEN-1:0]   ra_val,
  input  logic              writes_base,
  output logic [XLEN-1:0]   base,
  output logic              ra_is_zero
);

  always_comb begin
    ra_is_zero = (ra_num == '0);
    if (ra_is_zero && !writes_base)
      base = '0;
    else
      base = ra_val;
  end

endmodule

// File: rtl/fpl_ea_add.sv
module fpl_ea_add #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16
) (
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [DISP_W-1:0] disp,
  input  logic              use_reg_ofs,
  output logic [XLEN-1:0]   sum
);

  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] ofs;

  always_comb begin
    if (use_reg_ofs)
      ofs = rb_val;
    else
      ofs = {{EXT_W{disp[DISP_W-1]}}, disp};
    sum = base + ofs;
  end

endmodule

// File: rtl/fpl_agen.sv
module fpl_agen
  import fpl_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int DISP_W  = 16,
  parameter int RIDX_W  = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic [OP_W-1:0]      op,
  input  logic [RIDX_W-1:0]    ra_num,
  input  logic [XLEN-1:0]      ra_val,
  input  logic [XLEN-1:0]      rb_val,
  input  logic [DISP_W-1:0]    disp,
  output logic                 valid_out,
  output logic [XLEN-1:0]      ea,
  output logic                 wb_en,
  output logic [XLEN-1:0]      wb_data,
  output logic [NBYTE_W-1:0]   nbytes,
  output logic                 bad_form
);

  localparam int EXT_W = XLEN - DISP_W;

  fpl_ctl_t        ctl;
  logic [XLEN-1:0] base;
  logic            ra_zero;
  logic [XLEN-1:0] sum;
  logic            bad_c;
  logic            wb_c;

  fpl_decode u_dec (
    .op  (op),
    .ctl (ctl)
  );

  fpl_base_sel #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_base (
    .ra_num      (ra_num),
    .ra_val      (ra_val),
    .writes_base (ctl.writes_base),
    .base        (base),
    .ra_is_zero  (ra_zero)
  );

  fpl_ea_add #(.XLEN(XLEN), .DISP_W(DISP_W)) u_add (
    .base        (base),
    .rb_val      (rb_val),
    .disp        (disp),
    .use_reg_ofs (ctl.use_reg_ofs),
    .sum         (sum)
  );

  always_comb begin
    bad_c = ctl.form_err | (ctl.writes_base & ra_zero);
    wb_c  = ctl.writes_base & ~bad_c;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_out <= 1'b0;
          ea        <= '0;
          wb_en     <= 1'b0;
          wb_data   <= '0;
          nbytes    <= '0;
          bad_form  <= 1'b0;
        end else begin
          valid_out <= valid_in;
          if (valid_in) begin
            ea       <= sum;
            wb_en    <= wb_c;
            wb_data  <= sum;
            nbytes   <= ctl.nbytes;
            bad_form <= bad_c;
          end
        end
      end

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out); // R9
      AST_HOLD_EA: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(ea) && !valid_out)); // R9
      AST_WB_NEVER_BAD: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !bad_form); // R8
      AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> (nbytes == NBYTE_W'(4) || nbytes == NBYTE_W'(8))); // R6
      AST_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op[1:0] == 2'b00 && ra_num == '0)
        |=> ea == $past({{EXT_W{disp[DISP_W-1]}}, disp})); // R3
      AST_UPDATE_WB: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op[1] && !op[3] && ra_num != '0)
        |=> (wb_en && wb_data == ea)); // R5
      AST_WORD_FORM: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op[3] && op[1:0] != 2'b01) |=> (bad_form && !wb_en)); // R7
    end else begin : g_comb
      always_comb begin
        valid_out = valid_in;
        ea        = sum;
        wb_en     = wb_c & valid_in;
        wb_data   = sum;
        nbytes    = ctl.nbytes;
        bad_form  = bad_c;
      end
    end
  endgenerate

endmodule

// File: tb/fpl_agen_test.sv
module fpl_agen_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_in;
  logic [3:0]  op;
  logic [4:0]  ra_num;
  logic [63:0] ra_val;
  logic [63:0] rb_val;
  logic [15:0] disp;
  logic        valid_out;
  logic [63:0] ea;
  logic        wb_en;
  logic [63:0] wb_data;
  logic [3:0]  nbytes;
  logic        bad_form;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [63:0] exp_ea;
  logic        exp_wb;
  logic [3:0]  exp_nb;
  logic        exp_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpl_agen uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op(op), .ra_num(ra_num),
    .ra_val(ra_val), .rb_val(rb_val), .disp(disp), .valid_out(valid_out),
    .ea(ea), .wb_en(wb_en), .wb_data(wb_data), .nbytes(nbytes),
    .bad_form(bad_form)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // reference built from the requirements
  task automatic model(input logic [3:0] o, input logic [4:0] rn,
                       input logic [63:0] ra, input logic [63:0] rb,
                       input logic [15:0] d);
    logic [63:0] b;
    logic bad;
    b = (!o[1] && rn == 5'd0) ? 64'd0 : ra;                    // R3 R4
    exp_ea = o[0] ? b + rb : b + {{48{d[15]}}, d};              // R1 R2
    exp_nb = (o[3:2] == 2'b01) ? 4'd8 : 4'd4;                   // R6
    bad = (o[3] && o[1:0] != 2'b01) || (o[1] && rn == 5'd0);    // R7 R8
    exp_bad = bad;
    exp_wb = o[1] && !bad;                                       // R5
  endtask

  task automatic issue(input logic [3:0] o, input logic [4:0] rn,
                       input logic [63:0] ra, input logic [63:0] rb,
                       input logic [15:0] d, input string tag);
    @(negedge clk);
    valid_in = 1'b1; op = o; ra_num = rn; ra_val = ra; rb_val = rb; disp = d;
    model(o, rn, ra, rb, d);
    @(negedge clk);
    valid_in = 1'b0;
    chk({tag, " R9 valid_out"}, {63'd0, valid_out}, 64'd1);
    chk({tag, " ea"}, ea, exp_ea);
    chk({tag, " R5 wb_en"}, {63'd0, wb_en}, {63'd0, exp_wb});
    if (exp_wb) chk({tag, " R5 wb_data"}, wb_data, exp_ea);
    chk({tag, " R6 nbytes"}, {60'd0, nbytes}, {60'd0, exp_nb});
    chk({tag, " bad_form"}, {63'd0, bad_form}, {63'd0, exp_bad});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    rst = 1'b1; valid_in = 1'b0; op = '0; ra_num = '0;
    ra_val = '0; rb_val = '0; disp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 valid_out", {63'd0, valid_out}, 64'd0);
    chk("R10 ea", ea, 64'd0);
    chk("R10 wb_en", {63'd0, wb_en}, 64'd0);
    chk("R10 wb_data", wb_data, 64'd0);
    chk("R10 nbytes", {60'd0, nbytes}, 64'd0);
    chk("R10 bad_form", {63'd0, bad_form}, 64'd0);

    issue(4'b0000, 5'd3, 64'h1000, 64'h0, 16'hFFF0, "R1 single disp neg");
    issue(4'b0100, 5'd3, 64'h1000, 64'h0, 16'h7FFF, "R1 double disp pos");
    issue(4'b0001, 5'd7, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 16'h0, "R2 wrap");
    issue(4'b1001, 5'd7, 64'h20, 64'h8, 16'h0, "R2 word signed idx");
    issue(4'b0000, 5'd0, 64'hDEAD_BEEF, 64'h0, 16'h0008, "R3 zero base disp");
    issue(4'b1101, 5'd0, 64'hDEAD_BEEF, 64'h40, 16'h0, "R3 zero base idx");
    issue(4'b0110, 5'd0, 64'h5000, 64'h0, 16'h0010, "R4 R8 update ra0");
    issue(4'b0111, 5'd4, 64'h5000, 64'h100, 16'h0, "R4 R5 update idx");
    issue(4'b0010, 5'd9, 64'h8000, 64'h0, 16'h8000, "R5 update disp");
    issue(4'b1000, 5'd2, 64'h100, 64'h0, 16'h4, "R7 word disp form");
    issue(4'b1111, 5'd2, 64'h100, 64'h8, 16'h0, "R7 word update form");

    // R9 hold: new inputs without valid_in
    held = ea;
    @(negedge clk);
    op = 4'b0101; ra_num = 5'd1; ra_val = 64'h1234; rb_val = 64'h9;
    @(negedge clk);
    chk("R9 hold valid_out", {63'd0, valid_out}, 64'd0);
    chk("R9 hold ea", ea, held);
    chk("R9 hold bad_form", {63'd0, bad_form}, {63'd0, exp_bad});
    chk("R9 hold nbytes", {60'd0, nbytes}, {60'd0, exp_nb});

    for (int i = 0; i < 400; i++) begin
      logic [4:0] rn;
      rn = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      issue(4'($urandom), rn, {$urandom, $urandom}, {$urandom, $urandom},
            16'($urandom), "R1 R2 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule